// File: doc/BRIEF.md
# Lane Link Startup Sequencer

This block is the link-layer sequencer of a multi-lane serial converter transmitter. It follows the receiver's active-low synchronization request, `sync_n`. While the request is asserted, every lane sends the comma control character so that the receiver can lock its code groups. When the request is released, the block sends a lane alignment sequence. That sequence lasts a fixed number of multiframes. The block then passes sample octets through from its input stream. Every lane produces one octet per clock, together with a flag that marks the octet as a control character. A later 8b/10b encoder consumes both. A start-of-multiframe strobe comes from the block's internal octet/multiframe counter.

A 3-bit test-mode input can override normal traffic with link test patterns:
- a continuous high-frequency jitter pattern,
- a continuous stream of commas,
- endless repetition of the alignment sequence.

The default configuration is 4 lanes, 2 octets per frame and 16 frames per multiframe, so one multiframe is 32 clocks. The alignment sequence is 4 multiframes long, or 128 clocks.

The sample input is a valid/ready stream. `s_ready` is high only while sample data is actually being transmitted. A beat moves when `s_valid` and `s_ready` are both high. The output side has no back-pressure, because the serializer takes one octet per lane on every clock. If `s_valid` is low while `s_ready` is high, the lanes send zero data octets. `sync_n` is expected to be synchronous to `clk`.

Top module: `lane_link_sequencer`

## Requirements
- R1: Reset state is code-group sync. In that state every lane outputs 0xBC (K28.5) with its control flag set, while `s_ready` and `tx_somf` are 0.
- R2: In code-group sync with test mode 3'b000, every lane outputs 0xBC with its control flag set, and `s_ready` is 0.
- R3: Suppose `sync_n` is sampled high in code-group sync. The alignment sequence then starts on the next clock and lasts exactly 4 × 16 × 2 = 128 clocks, after which the data state begins.
- R4: In every alignment multiframe, octet 0 is 0x1C (K28.0) and octet 31 is 0x7C (K28.3), both with the control flag set.
- R5: In alignment multiframe 1 (counting from 0), octet 1 is 0x9C (K28.4) with the control flag set. Octets 2 to 15 are 0x00 configuration octets with the flag clear.
- R6: Every other alignment octet equals its position (0 to 31) within the multiframe, with the control flag clear.
- R7: In the data state, `s_ready` is 1. Lane i sends `s_data[8i+7:8i]` when `s_valid` is high and 0x00 otherwise, always with the flag clear. `s_ready` is 0 in every other state.
- R8: `sync_n` low in any state returns the block to code-group sync on the next clock.
- R9: `tx_somf` is 1 exactly on octet 0 of each multiframe during alignment and data, and 0 in code-group sync.
- R10: Test mode 3'b001 makes all lanes send 0xB5 (D21.5) with the flag clear and holds `s_ready` at 0. The state sequence continues underneath.
- R11: Test mode 3'b010 makes all lanes send 0xBC with the flag set and holds `s_ready` at 0.
- R12: Test mode 3'b011 makes the alignment sequence restart instead of ending. In the data state, this mode returns the block to alignment after octet 31 of the current multiframe.
- R13: Test modes 3'b100 to 3'b111 behave exactly like 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_n | input | 1 | Active-low synchronization request from the receiver |
| test_mode | input | 3 | Link test-mode select |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready; high only while samples are sent |
| s_data | input | LANES*8 | One sample octet per lane, lane 0 in the low byte |
| tx_data | output | LANES*8 | Octet per lane toward the encoder |
| tx_is_ctrl | output | LANES | Per-lane control-character flag |
| tx_somf | output | 1 | Start-of-multiframe strobe |

## Verification
The bench goes after the length of the alignment sequence. A counter that is off by one would make `s_ready` rise a clock early or late and would shift every K28.0/K28.3 marker. It also drops `sync_n` in the middle of alignment and in the middle of data, where a sequencer that ignored the request would keep sending alignment or sample octets instead of commas. In repeat-alignment mode, a design that failed to clear the multiframe index on re-entry from data would put the K28.4 marker in the wrong multiframe. Random switching between test modes checks that the jitter patterns override every state and never open `s_ready`.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_ILA  = 2'd1,
    ST_DATA = 2'd2
  } lsq_state_e;

  typedef enum logic [1:0] {
    SRC_COMMA  = 2'd0,
    SRC_HFJ    = 2'd1,
    SRC_ILA    = 2'd2,
    SRC_SAMPLE = 2'd3
  } lsq_src_e;

  localparam logic [7:0] K28_5 = 8'hBC;
  localparam logic [7:0] K28_0 = 8'h1C;
  localparam logic [7:0] K28_3 = 8'h7C;
  localparam logic [7:0] K28_4 = 8'h9C;
  localparam logic [7:0] D21_5 = 8'hB5;

  localparam logic [2:0] TM_NORMAL   = 3'b000;
  localparam logic [2:0] TM_HFJ      = 3'b001;
  localparam logic [2:0] TM_COMMA    = 3'b010;
  localparam logic [2:0] TM_ILA_LOOP = 3'b011;

endpackage

// File: rtl/lsq_mf_counter.sv
module lsq_mf_counter #(
  parameter int MF_OCTETS = 32,
  parameter int NUM_MF    = 4,
  localparam int POS_W    = (MF_OCTETS > 1) ? $clog2(MF_OCTETS) : 1,
  localparam int MF_W     = (NUM_MF > 1) ? $clog2(NUM_MF) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [POS_W-1:0] pos,
  output logic [MF_W-1:0]  mf_idx,
  output logic             mf_last,
  output logic             seq_last
);

  assign mf_last  = (pos == POS_W'(MF_OCTETS - 1));
  assign seq_last = mf_last && (mf_idx == MF_W'(NUM_MF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pos    <= '0;
      mf_idx <= '0;
    end else if (advance) begin
      if (mf_last) begin
        pos    <= '0;
        mf_idx <= (mf_idx == MF_W'(NUM_MF - 1)) ? '0 : mf_idx + MF_W'(1);
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/lsq_ila_gen.sv
module lsq_ila_gen
  import lsq_pkg::*;
#(
  parameter int MF_OCTETS  = 32,
  parameter int CFG_OCTETS = 14,
  parameter int POS_W      = 5,
  parameter int MF_W       = 2,
  localparam int CFG_FIRST = 2,
  localparam int CFG_LAST  = CFG_FIRST + CFG_OCTETS - 1
) (
  input  logic [POS_W-1:0] pos,
  input  logic [MF_W-1:0]  mf_idx,
  output logic [7:0]       octet,
  output logic             is_k
);

  logic cfg_mf;
  assign cfg_mf = (mf_idx == MF_W'(1));

  always_comb begin
    octet = 8'(pos);
    is_k  = 1'b0;
    if (pos == '0) begin
      octet = K28_0;
      is_k  = 1'b1;
    end else if (pos == POS_W'(MF_OCTETS - 1)) begin
      octet = K28_3;
      is_k  = 1'b1;
    end else if (cfg_mf && pos == POS_W'(1)) begin
      octet = K28_4;
      is_k  = 1'b1;
    end else if (cfg_mf && pos >= POS_W'(CFG_FIRST) && pos <= POS_W'(CFG_LAST)) begin
      octet = 8'h00;
    end
  end

endmodule

// File: rtl/lsq_lane_mux.sv
module lsq_lane_mux
  import lsq_pkg::*;
#(
  parameter int LANES = 4,
  localparam int DW   = LANES * 8
) (
  input  lsq_src_e         src,
  input  logic             s_valid,
  input  logic [DW-1:0]    s_data,
  input  logic [7:0]       ila_octet,
  input  logic             ila_k,
  output logic [DW-1:0]    tx_data,
  output logic [LANES-1:0] tx_is_ctrl
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (src)
        SRC_COMMA: begin
          tx_data[g*8 +: 8] = K28_5;
          tx_is_ctrl[g]     = 1'b1;
        end
        SRC_HFJ: begin
          tx_data[g*8 +: 8] = D21_5;
          tx_is_ctrl[g]     = 1'b0;
        end
        SRC_ILA: begin
          tx_data[g*8 +: 8] = ila_octet;
          tx_is_ctrl[g]     = ila_k;
        end
        default: begin
          tx_data[g*8 +: 8] = s_valid ? s_data[g*8 +: 8] : 8'h00;
          tx_is_ctrl[g]     = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lane_link_sequencer.sv
module lane_link_sequencer
  import lsq_pkg::*;
#(
  parameter int LANES            = 4,
  parameter int OCTETS_PER_FRAME = 2,
  parameter int FRAMES_PER_MF    = 16,
  parameter int ILA_MULTIFRAMES  = 4,
  parameter int CFG_OCTETS       = 14,
  localparam int DW        = LANES * 8,
  localparam int MF_OCTETS = OCTETS_PER_FRAME * FRAMES_PER_MF,
  localparam int POS_W     = (MF_OCTETS > 1) ? $clog2(MF_OCTETS) : 1,
  localparam int MF_W      = (ILA_MULTIFRAMES > 1) ? $clog2(ILA_MULTIFRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic [2:0]       test_mode,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [DW-1:0]    s_data,
  output logic [DW-1:0]    tx_data,
  output logic [LANES-1:0] tx_is_ctrl,
  output logic             tx_somf
);

  initial begin
    if (MF_OCTETS < CFG_OCTETS + 3)
      $error("multiframe too short for configuration octets");
    if (ILA_MULTIFRAMES < 2)
      $error("alignment needs at least two multiframes");
  end

  lsq_state_e       state_q, state_d;
  logic [POS_W-1:0] pos;
  logic [MF_W-1:0]  mf_idx;
  logic             mf_last, seq_last;
  logic             cnt_clear;
  logic             mode_hfj, mode_comma, mode_loop;
  lsq_src_e         src;
  logic [7:0]       ila_octet;
  logic             ila_k;

  assign mode_hfj   = (test_mode == TM_HFJ);
  assign mode_comma = (test_mode == TM_COMMA);
  assign mode_loop  = (test_mode == TM_ILA_LOOP);

  always_comb begin
    state_d = state_q;
    if (!sync_n) begin
      state_d = ST_CGS;
    end else begin
      case (state_q)
        ST_CGS:  state_d = ST_ILA;
        ST_ILA:  if (seq_last && !mode_loop) state_d = ST_DATA;
        ST_DATA: if (mf_last && mode_loop) state_d = ST_ILA;
        default: state_d = ST_CGS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_CGS;
    else        state_q <= state_d;
  end

  assign cnt_clear = (state_d == ST_CGS) ||
                     (state_q == ST_DATA && state_d == ST_ILA);

  lsq_mf_counter #(
    .MF_OCTETS (MF_OCTETS),
    .NUM_MF    (ILA_MULTIFRAMES)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .advance  (state_q != ST_CGS),
    .pos      (pos),
    .mf_idx   (mf_idx),
    .mf_last  (mf_last),
    .seq_last (seq_last)
  );

  lsq_ila_gen #(
    .MF_OCTETS  (MF_OCTETS),
    .CFG_OCTETS (CFG_OCTETS),
    .POS_W      (POS_W),
    .MF_W       (MF_W)
  ) u_ila (
    .pos    (pos),
    .mf_idx (mf_idx),
    .octet  (ila_octet),
    .is_k   (ila_k)
  );

  always_comb begin
    if (mode_hfj)        src = SRC_HFJ;
    else if (mode_comma) src = SRC_COMMA;
    else begin
      case (state_q)
        ST_ILA:  src = SRC_ILA;
        ST_DATA: src = SRC_SAMPLE;
        default: src = SRC_COMMA;
      endcase
    end
  end

  lsq_lane_mux #(.LANES(LANES)) u_mux (
    .src        (src),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .ila_octet  (ila_octet),
    .ila_k      (ila_k),
    .tx_data    (tx_data),
    .tx_is_ctrl (tx_is_ctrl)
  );

  assign s_ready = (src == SRC_SAMPLE);
  assign tx_somf = (state_q != ST_CGS) && (pos == '0);

endmodule

// File: rtl/lsq_chk.sv
module lsq_chk
  import lsq_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_n,
  input logic [2:0]       test_mode,
  input logic             s_ready,
  input logic [LANES*8-1:0] tx_data,
  input logic [LANES-1:0] tx_is_ctrl,
  input logic             tx_somf,
  input lsq_state_e       state_q
);

  // R3
  cgs_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CGS && sync_n) |=> (state_q == ST_ILA));

  // R8
  sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (state_q == ST_CGS && !tx_somf && !s_ready));

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (state_q == ST_DATA && test_mode != TM_HFJ && test_mode != TM_COMMA));

  // R9
  somf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_somf |=> !tx_somf);

  // R10
  hfj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == TM_HFJ) |-> (tx_is_ctrl == '0 && !s_ready));

  // R2
  comma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CGS && test_mode == TM_NORMAL) |-> (tx_data[7:0] == K28_5 && tx_is_ctrl[0]));

endmodule

bind lane_link_sequencer lsq_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_n     (sync_n),
  .test_mode  (test_mode),
  .s_ready    (s_ready),
  .tx_data    (tx_data),
  .tx_is_ctrl (tx_is_ctrl),
  .tx_somf    (tx_somf),
  .state_q    (state_q)
);

// File: tb/lane_link_sequencer_tb.sv
`timescale 1ns/1ps
module lane_link_sequencer_tb;

  localparam int LANES   = 4;
  localparam int MFO     = 32;
  localparam int ILA_LEN = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sync_n = 1'b0;
  logic [2:0]        test_mode = 3'b000;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [LANES*8-1:0] s_data = '0;
  logic [LANES*8-1:0] tx_data;
  logic [LANES-1:0]  tx_is_ctrl;
  logic              tx_somf;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string focus = "";

  // reference model: 0 code-group sync, 1 alignment, 2 data
  int st = 0;
  int c = 0;

  always #2.5 clk = ~clk;

  lane_link_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .test_mode(test_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .tx_data(tx_data), .tx_is_ctrl(tx_is_ctrl), .tx_somf(tx_somf)
  );

  function automatic logic [8:0] exp_octet(int lane);
    int p, m;
    p = c % MFO;
    m = c / MFO;
    if (test_mode == 3'b001) return {1'b0, 8'hB5};
    if (test_mode == 3'b010) return {1'b1, 8'hBC};
    if (st == 0) return {1'b1, 8'hBC};
    if (st == 2) return {1'b0, s_valid ? s_data[lane*8 +: 8] : 8'h00};
    if (p == 0) return {1'b1, 8'h1C};
    if (p == MFO - 1) return {1'b1, 8'h7C};
    if (m == 1 && p == 1) return {1'b1, 8'h9C};
    if (m == 1 && p >= 2 && p <= 15) return {1'b0, 8'h00};
    return {1'b0, 8'(p)};
  endfunction

  function automatic string data_tag();
    int p, m;
    p = c % MFO;
    m = c / MFO;
    if (test_mode == 3'b001) return "R10";
    if (test_mode == 3'b010) return "R11";
    if (test_mode[2]) return "R13";
    if (st == 0) return "R2";
    if (st == 2) return "R7";
    if (p == 0 || p == MFO - 1) return "R4";
    if (m == 1 && p <= 15) return "R5";
    return "R6";
  endfunction

  task automatic check_outputs();
    logic [LANES*8-1:0] ed;
    logic [LANES-1:0]   ec;
    logic er, es;
    for (int i = 0; i < LANES; i++) begin
      logic [8:0] o;
      o = exp_octet(i);
      ed[i*8 +: 8] = o[7:0];
      ec[i] = o[8];
    end
    er = (st == 2) && (test_mode != 3'b001) && (test_mode != 3'b010);
    es = (st != 0) && (c % MFO == 0);
    vectors++;
    if (tx_data !== ed || tx_is_ctrl !== ec) begin
      fails++;
      $display("FAIL %s %s: data=%h ctrl=%b expected data=%h ctrl=%b", data_tag(), focus,
               tx_data, tx_is_ctrl, ed, ec);
    end
    vectors++;
    if (s_ready !== er) begin
      fails++;
      $display("FAIL R7 %s: s_ready=%b expected %b", focus, s_ready, er);
    end
    vectors++;
    if (tx_somf !== es) begin
      fails++;
      $display("FAIL R9 %s: tx_somf=%b expected %b", focus, tx_somf, es);
    end
  endtask

  task automatic model_step();
    if (!sync_n) begin
      st = 0; c = 0;
    end else if (st == 0) begin
      st = 1; c = 0;
    end else if (st == 1) begin
      if (c == ILA_LEN - 1) begin
        if (test_mode == 3'b011) c = 0;
        else begin st = 2; c = c + 1; end
      end else c = c + 1;
    end else begin
      if (test_mode == 3'b011 && c % MFO == MFO - 1) begin
        st = 1; c = 0;
      end else c = c + 1;
    end
  endtask

  task automatic cyc(input logic sy, input logic [2:0] md, input logic v,
                     input logic [LANES*8-1:0] d);
    @(negedge clk);
    sync_n = sy; test_mode = md; s_valid = v; s_data = d;
    #1;
    check_outputs();
    @(posedge clk);
    model_step();
  endtask

  task automatic run(input int n, input logic sy, input logic [2:0] md);
    for (int i = 0; i < n; i++) cyc(sy, md, 1'($urandom % 2), $urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    st = 0; c = 0;

    focus = "R1";
    cyc(1'b0, 3'b000, 1'b0, '0);
    focus = "R2";
    run(5, 1'b0, 3'b000);

    // full startup: alignment length and markers
    focus = "R3";
    run(ILA_LEN + 40, 1'b1, 3'b000);

    // request dropped in data, then in the middle of alignment
    focus = "R8";
    run(3, 1'b0, 3'b000);
    run(50, 1'b1, 3'b000);
    run(2, 1'b0, 3'b000);
    run(ILA_LEN + 10, 1'b1, 3'b000);

    // repeated alignment, then re-entry from data
    focus = "R12";
    run(3, 1'b0, 3'b000);
    run(2 * ILA_LEN + 20, 1'b1, 3'b011);
    run(ILA_LEN, 1'b1, 3'b000);
    run(80, 1'b1, 3'b011);
    run(2 * ILA_LEN, 1'b1, 3'b000);

    focus = "R10";
    run(40, 1'b1, 3'b001);
    run(3, 1'b0, 3'b001);
    focus = "R11";
    run(40, 1'b1, 3'b010);
    focus = "R13";
    for (int m = 4; m < 8; m++) begin
      run(2, 1'b0, 3'(m));
      run(ILA_LEN + 10, 1'b1, 3'(m));
    end

    focus = "random";
    for (int ph = 0; ph < 40; ph++) begin
      int hi;
      run(1 + $urandom % 6, 1'b0, 3'b000);
      hi = $urandom % 320;
      for (int k = 0; k < hi; k++) begin
        logic [2:0] md;
        md = ($urandom % 10 < 7) ? 3'b000 : 3'($urandom % 8);
        cyc(1'b1, md, 1'($urandom % 2), $urandom);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule